// File: doc/BRIEF.md
# LCD Color Lookup Table With Auto-Advancing Index

This block turns pixel codes into 18-bit RGB values for an LCD controller. It holds a table of 256 colors, each with 6 bits of red, green and blue. A processor loads the table through two register locations. One is a control word that holds the entry index, a 4-bit page number and two auto-advance enables. The other is a data port that reads or writes the entry the index points at. The index can step forward by itself after every data read, after every data write, or after both, so a full table load or dump needs only one index setup.

On the display side, one pixel code and a 2-bit color mode arrive each cycle, and the color appears exactly one cycle later. In the two color modes the table is read. In the paged color mode, the index is the page number above the low nibble of the pixel. In the full color mode, the 8-bit pixel itself is the index. The two monochrome modes never touch the table: they produce a gray level that is copied into all three channels.

The table has a single port. When a display lookup and a processor data-port access fall in the same cycle, the display lookup wins. The processor access waits and is granted in the next cycle that has no lookup.

Top module: `lcd_clut`

## Requirements
- R1: A data-port write stores its 18-bit value in the entry selected by the index. A later data-port read of that entry returns the same value. The channel fields are red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R2: A control write (cpu_addr=0, cpu_we=1) loads the following fields from cpu_wdata:
  - the index, from bits 7:0;
  - the page, from bits 11:8;
  - the read-advance enable, from bit 12;
  - the write-advance enable, from bit 13.

  A control read returns the current values in the same bit positions, with the upper bits zero.
- R3: When the read-advance enable is 1, a granted data-port read advances the index by one after the read. When the enable is 0, the index is left unchanged.
- R4: When the write-advance enable is 1, a granted data-port write advances the index by one after the write. When the enable is 0, the index is left unchanged. Index 255 advances to 0.
- R5: In mode 3, a pixel with pix_valid=1 gives rgb_valid=1 in the next cycle, with rgb_out equal to the entry at pix_code.
- R6: In mode 2, the entry used is {page, pix_code[3:0]}, and pix_code[7:4] has no effect. The result arrives one cycle later.
- R7: In mode 0, rgb_out is all ones one cycle later when pix_code[0]=1, and all zeros when pix_code[0]=0.
- R8: In mode 1, each 6-bit channel is pix_code[1:0] repeated three times, giving the levels 0, 21, 42 and 63. All three channels are equal, and the result arrives one cycle later.
- R9: cpu_gnt follows these rules in each cycle:
  - A control access is granted in the cycle it is requested.
  - A data-port request is refused in any cycle with pix_valid=1 in mode 2 or 3.
  - A data-port request is granted in the first cycle without such a lookup.
  - Pixels in modes 0 and 1 never block a data-port request.
- R10: cpu_rvalid is 1 in the cycle after each granted read, and only then, with the read value on cpu_rdata.
- R11: After reset, the following are all zero: the index, the page, both advance enables, rgb_valid and cpu_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cpu_req | input | 1 | Register access request, held until granted |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 1 | 0 for the control word, 1 for the data port |
| cpu_wdata | input | 18 | Write data |
| cpu_gnt | output | 1 | The access is taken at this clock edge |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 18 | Read data |
| pix_valid | input | 1 | A pixel code is present |
| pix_code | input | 8 | Pixel code |
| color_mode | input | 2 | 0 is mono, 1 is 4-level gray, 2 is paged color, 3 is full color |
| rgb_valid | output | 1 | Color output valid |
| rgb_out | output | 18 | 6-6-6 color |

## Verification
A wrong index does not show at once. It shows as a data-port read that returns another entry's value, or as a control read whose index field is off by one. Either one is seen one cycle after the granted read. A wrong page or mode decode shows on rgb_out in the cycle after the pixel. An arbitration fault shows in the same cycle, as cpu_gnt high during a color lookup. It can also show one cycle later, as a color read from the processor's address instead of the pixel's.

// File: rtl/lcd_clut_pkg.sv
package lcd_clut_pkg;
   typedef enum logic [1:0] {
      MODE_MONO  = 2'd0,
      MODE_GRAY4 = 2'd1,
      MODE_PAGED = 2'd2,
      MODE_FULL  = 2'd3
   } clut_mode_e;

   localparam logic SEL_CTRL = 1'b0;
   localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/clut_regs.sv
module clut_regs #(
   parameter int IDX_W  = 8,
   parameter int PAGE_W = 4,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              data_acc,
   input  logic              data_we,
   output logic [IDX_W-1:0]  idx,
   output logic [PAGE_W-1:0] page,
   output logic [DATA_W-1:0] ctrl_word
);
   localparam int RDI_BIT = IDX_W + PAGE_W;
   localparam int WRI_BIT = RDI_BIT + 1;
   localparam int PAD_W   = DATA_W - WRI_BIT - 1;

   logic rd_adv, wr_adv, step;

   assign step = data_acc & (data_we ? wr_adv : rd_adv);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= '0;
         page   <= '0;
         rd_adv <= 1'b0;
         wr_adv <= 1'b0;
      end else if (ctrl_wr) begin
         idx    <= wdata[IDX_W-1:0];
         page   <= wdata[RDI_BIT-1:IDX_W];
         rd_adv <= wdata[RDI_BIT];
         wr_adv <= wdata[WRI_BIT];
      end else if (step) begin
         idx <= idx + 1'b1;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign ctrl_word = {{PAD_W{1'b0}}, wr_adv, rd_adv, page, idx};
      end else begin : g_nopad
         assign ctrl_word = {wr_adv, rd_adv, page, idx};
      end
   endgenerate
endmodule

// File: rtl/clut_pixmap.sv
module clut_pixmap
   import lcd_clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int PAGE_W = 4,
   parameter int CH_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_valid,
   input  logic [IDX_W-1:0]   pix_code,
   input  logic [1:0]         color_mode,
   input  logic [PAGE_W-1:0]  page,
   output logic               pal_req,
   output logic [IDX_W-1:0]   pal_idx,
   output logic               out_valid,
   output logic               out_use_pal,
   output logic [3*CH_W-1:0]  out_bypass
);
   localparam int LOW_W = IDX_W - PAGE_W;

   clut_mode_e mode;
   logic [CH_W-1:0]   gray_ch, mono_ch;
   logic [3*CH_W-1:0] byp_n;

   assign mode    = clut_mode_e'(color_mode);
   assign pal_req = pix_valid & color_mode[1];
   assign pal_idx = (mode == MODE_FULL) ? pix_code
                                        : {page, pix_code[LOW_W-1:0]};

   genvar gi;
   generate
      for (gi = 0; gi < CH_W; gi++) begin : g_rep
         assign gray_ch[gi] = pix_code[gi % 2];
      end
   endgenerate

   assign mono_ch = {CH_W{pix_code[0]}};
   assign byp_n   = (mode == MODE_MONO) ? {3{mono_ch}} : {3{gray_ch}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_use_pal <= 1'b0;
         out_bypass  <= '0;
      end else begin
         out_valid   <= pix_valid;
         out_use_pal <= pal_req;
         if (pix_valid && !color_mode[1])
            out_bypass <= byp_n;
      end
   end
endmodule

// File: rtl/clut_store.sv
module clut_store #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[addr] <= wdata;
      if (re)
         rdata <= cells[addr];
   end
endmodule

// File: rtl/lcd_clut.sv
module lcd_clut
   import lcd_clut_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int CH_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic                cpu_addr,
   input  logic [3*CH_W-1:0]   cpu_wdata,
   output logic                cpu_gnt,
   output logic                cpu_rvalid,
   output logic [3*CH_W-1:0]   cpu_rdata,
   input  logic                pix_valid,
   input  logic [IDX_W-1:0]    pix_code,
   input  logic [1:0]          color_mode,
   output logic                rgb_valid,
   output logic [3*CH_W-1:0]   rgb_out
);
   localparam int PAGE_W = IDX_W / 2;
   localparam int DATA_W = 3 * CH_W;

   generate
      if (IDX_W % 2 != 0) begin : g_bad_idx
         $error("lcd_clut: IDX_W must be even");
      end
      if (CH_W < 2) begin : g_bad_ch
         $error("lcd_clut: CH_W must be at least 2");
      end
      if (IDX_W + PAGE_W + 2 > DATA_W) begin : g_bad_fit
         $error("lcd_clut: control word does not fit the data width");
      end
   endgenerate

   logic              pal_req, data_go, ctrl_wr, mem_we, mem_re;
   logic [IDX_W-1:0]  pal_idx, cur_idx, mem_addr;
   logic [PAGE_W-1:0] cur_page;
   logic [DATA_W-1:0] ctrl_word, ctrl_q, mem_q, bypass_q;
   logic              use_pal_q, rd_ctrl_q;

   assign cpu_gnt = cpu_req & ((cpu_addr == SEL_CTRL) | ~pal_req);
   assign data_go = cpu_gnt & (cpu_addr == SEL_DATA);
   assign ctrl_wr = cpu_gnt & (cpu_addr == SEL_CTRL) & cpu_we;
   assign mem_we  = data_go & cpu_we;
   assign mem_re  = pal_req | (data_go & ~cpu_we);
   assign mem_addr = pal_req ? pal_idx : cur_idx;

   clut_regs #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(cpu_wdata),
      .data_acc(data_go), .data_we(cpu_we), .idx(cur_idx),
      .page(cur_page), .ctrl_word(ctrl_word)
   );

   clut_pixmap #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .CH_W(CH_W)) u_map (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_code(pix_code),
      .color_mode(color_mode), .page(cur_page), .pal_req(pal_req),
      .pal_idx(pal_idx), .out_valid(rgb_valid), .out_use_pal(use_pal_q),
      .out_bypass(bypass_q)
   );

   clut_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
      .wdata(cpu_wdata), .rdata(mem_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rvalid <= 1'b0;
         rd_ctrl_q  <= 1'b0;
         ctrl_q     <= '0;
      end else begin
         cpu_rvalid <= cpu_gnt & ~cpu_we;
         rd_ctrl_q  <= (cpu_addr == SEL_CTRL);
         if (cpu_gnt && !cpu_we && cpu_addr == SEL_CTRL)
            ctrl_q <= ctrl_word;
      end
   end

   assign cpu_rdata = rd_ctrl_q ? ctrl_q : mem_q;
   assign rgb_out   = use_pal_q ? mem_q : bypass_q;
endmodule

// File: rtl/clut_chk.sv
module clut_chk #(
   parameter int IDX_W = 8,
   parameter int CH_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_addr,
   input logic              cpu_gnt,
   input logic              cpu_rvalid,
   input logic              pix_valid,
   input logic [1:0]        color_mode,
   input logic              rgb_valid,
   input logic [3*CH_W-1:0] rgb_out
);
   p_ctrl_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_addr) |-> cpu_gnt);

   p_lookup_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_addr && pix_valid && color_mode[1]) |-> !cpu_gnt);

   p_free_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !(pix_valid && color_mode[1])) |-> cpu_gnt);

   p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && !cpu_we) |=> cpu_rvalid);

   p_rvalid_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_gnt && !cpu_we) |=> !cpu_rvalid);

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> rgb_valid);

   p_mono_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && color_mode == 2'd0) |=> (rgb_out == '0 || &rgb_out));

   p_gray_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && color_mode == 2'd1) |=>
      (rgb_out[3*CH_W-1:2*CH_W] == rgb_out[2*CH_W-1:CH_W] &&
       rgb_out[2*CH_W-1:CH_W] == rgb_out[CH_W-1:0]));
endmodule

bind lcd_clut clut_chk #(.IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid),
   .pix_valid(pix_valid), .color_mode(color_mode), .rgb_valid(rgb_valid),
   .rgb_out(rgb_out)
);

// File: tb/sim_lcd_clut.sv
`timescale 1ns/1ps
module sim_lcd_clut;
   localparam int DW = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_addr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_gnt, cpu_rvalid;
   logic [DW-1:0] cpu_rdata;
   logic pix_valid = 1'b0;
   logic [7:0] pix_code = '0;
   logic [1:0] color_mode = '0;
   logic rgb_valid;
   logic [DW-1:0] rgb_out;

   int checks = 0, errors = 0;

   logic [DW-1:0] m_mem [256];
   logic [7:0] m_idx = 0;
   logic [3:0] m_page = 0;
   logic m_rdi = 0, m_wri = 0;

   logic [DW-1:0] q_rgb [$];
   string         q_rgb_tag [$];
   logic [DW-1:0] q_cpu [$];
   string         q_cpu_tag [$];

   always #2.5 clk = ~clk;

   lcd_clut u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
      .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .pix_valid(pix_valid),
      .pix_code(pix_code), .color_mode(color_mode), .rgb_valid(rgb_valid),
      .rgb_out(rgb_out)
   );

   task automatic check(input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] val_of(input int i);
      return DW'((i * 18'h0A5B3) ^ 18'h15A5A);
   endfunction

   function automatic logic [DW-1:0] ctrl_of();
      return {4'b0, m_wri, m_rdi, m_page, m_idx};
   endfunction

   task automatic model_grant(input logic we, input logic addr,
                              input logic [DW-1:0] d, input string tag);
      if (!addr) begin
         if (we) begin
            m_idx = d[7:0]; m_page = d[11:8]; m_rdi = d[12]; m_wri = d[13];
         end else begin
            q_cpu.push_back(ctrl_of()); q_cpu_tag.push_back(tag);
         end
      end else if (we) begin
         m_mem[m_idx] = d;
         if (m_wri) m_idx = m_idx + 1;
      end else begin
         q_cpu.push_back(m_mem[m_idx]); q_cpu_tag.push_back(tag);
         if (m_rdi) m_idx = m_idx + 1;
      end
   endtask

   task automatic cpu_op(input logic we, input logic addr,
                         input logic [DW-1:0] d, input string tag);
      logic g;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = d;
      forever begin
         #1 g = cpu_gnt;
         @(posedge clk);
         if (g) break;
         @(negedge clk);
      end
      model_grant(we, addr, d, tag);
      #1 cpu_req = 1'b0;
   endtask

   function automatic logic [DW-1:0] exp_pix(input logic [1:0] md,
                                             input logic [7:0] c);
      logic [5:0] ch;
      case (md)
         2'd0: return c[0] ? '1 : '0;
         2'd1: begin ch = {c[1:0], c[1:0], c[1:0]}; return {ch, ch, ch}; end
         2'd2: return m_mem[{m_page, c[3:0]}];
         default: return m_mem[c];
      endcase
   endfunction

   task automatic drive_pix(input logic [1:0] md, input logic [7:0] c,
                            input string tag);
      @(negedge clk);
      pix_valid = 1'b1; color_mode = md; pix_code = c;
      q_rgb.push_back(exp_pix(md, c)); q_rgb_tag.push_back(tag);
      @(posedge clk);
      #1 pix_valid = 1'b0;
   endtask

   // monitor: pops the scoreboards as results appear
   always @(posedge clk) begin
      #1;
      if (rst_n && rgb_valid) begin
         if (q_rgb.size() == 0) check("R5 unexpected rgb_valid", 1, 0);
         else check(q_rgb_tag.pop_front(), rgb_out, q_rgb.pop_front());
      end
      if (rst_n && cpu_rvalid) begin
         if (q_cpu.size() == 0) check("R10 unexpected cpu_rvalid", 1, 0);
         else check(q_cpu_tag.pop_front(), cpu_rdata, q_cpu.pop_front());
      end
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      check("R11 rgb_valid after reset", DW'(rgb_valid), 0);
      check("R11 cpu_rvalid after reset", DW'(cpu_rvalid), 0);
      cpu_op(0, 0, 0, "R11 control word after reset");

      // write with advance
      cpu_op(1, 0, 18'h02010, "R2 ctrl write");
      for (int i = 0; i < 4; i++) cpu_op(1, 1, val_of(16 + i), "R4 wr");
      cpu_op(0, 0, 0, "R4 index advanced on writes / R2 fields");
      // read with advance
      cpu_op(1, 0, 18'h01010, "R2 ctrl write");
      for (int i = 0; i < 4; i++) cpu_op(0, 1, 0, "R1 R3 readback");
      cpu_op(0, 0, 0, "R3 index advanced on reads");
      // no advance
      cpu_op(1, 0, 18'h00020, "R2 ctrl write");
      cpu_op(1, 1, 18'h2ABCD, "R4 write no advance");
      cpu_op(0, 1, 0, "R1 read no advance");
      cpu_op(0, 1, 0, "R3 second read same entry");
      cpu_op(0, 0, 0, "R3 R4 index unchanged");
      // wrap
      cpu_op(1, 0, 18'h020FF, "R2 ctrl write");
      cpu_op(1, 1, 18'h3F000, "R4 write 255");
      cpu_op(1, 1, 18'h00FC0, "R4 write 0");
      cpu_op(0, 0, 0, "R4 index wrapped to 1");
      cpu_op(1, 0, 18'h010FF, "R2 ctrl write");
      cpu_op(0, 1, 0, "R1 entry 255");
      cpu_op(0, 1, 0, "R3 read wraps to entry 0");
      // fill page 3
      cpu_op(1, 0, 18'h02330, "R2 ctrl write page 3");
      for (int i = 0; i < 16; i++) cpu_op(1, 1, val_of(48 + i), "R4 fill");
      cpu_op(0, 0, 0, "R2 page field readback");

      // full color, back to back
      for (int i = 0; i < 6; i++) drive_pix(3, 8'(48 + i * 2), "R5 full mode");
      drive_pix(3, 8'h10, "R5 full mode 0x10");
      drive_pix(3, 8'hFF, "R5 full mode 0xFF");
      // paged
      drive_pix(2, 8'hA5, "R6 paged upper nibble ignored");
      drive_pix(2, 8'h0F, "R6 paged");
      drive_pix(2, 8'hF0, "R6 paged");
      // mono and gray
      drive_pix(0, 8'h01, "R7 mono on");
      drive_pix(0, 8'hFE, "R7 mono off");
      for (int i = 0; i < 4; i++) drive_pix(1, 8'(i + 8'hF0), "R8 gray level");

      // collision: color lookup beats data-port read
      cpu_op(1, 0, 18'h01034, "R2 ctrl write");
      @(negedge clk);
      pix_valid = 1'b1; color_mode = 2'd3; pix_code = 8'h3A;
      q_rgb.push_back(exp_pix(2'd3, 8'h3A)); q_rgb_tag.push_back("R9 lookup during collision");
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 1'b1;
      #1 check("R9 refused during lookup", DW'(cpu_gnt), 0);
      @(posedge clk);
      #1 pix_valid = 1'b0;
      #1 check("R9 granted next free cycle", DW'(cpu_gnt), 1);
      @(posedge clk);
      model_grant(0, 1, 0, "R9 R10 delayed read data");
      #1 cpu_req = 1'b0;

      // mono pixel does not block a data access
      @(negedge clk);
      pix_valid = 1'b1; color_mode = 2'd0; pix_code = 8'h01;
      q_rgb.push_back(exp_pix(2'd0, 8'h01)); q_rgb_tag.push_back("R7 mono beside access");
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 1'b1;
      #1 check("R9 mono pixel does not block", DW'(cpu_gnt), 1);
      @(posedge clk);
      model_grant(0, 1, 0, "R10 read beside mono pixel");
      #1 begin pix_valid = 1'b0; cpu_req = 1'b0; end

      // control access during lookup is still granted
      @(negedge clk);
      pix_valid = 1'b1; color_mode = 2'd2; pix_code = 8'h07;
      q_rgb.push_back(exp_pix(2'd2, 8'h07)); q_rgb_tag.push_back("R6 paged beside ctrl");
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 1'b0;
      #1 check("R9 control granted during lookup", DW'(cpu_gnt), 1);
      @(posedge clk);
      model_grant(0, 0, 0, "R2 ctrl read during lookup");
      #1 begin pix_valid = 1'b0; cpu_req = 1'b0; end

      repeat (4) @(posedge clk);
      #2;
      check("R10 all reads returned", DW'(q_cpu.size()), 0);
      check("R5 all pixels returned", DW'(q_rgb.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule